// File: doc/BRIEF.md
# Two-Channel PWM with Write-Pending Flags

This peripheral produces two independent pulse-width-modulated outputs from a memory-mapped register file. Each channel holds four 32-bit configuration words: control, clock divider, cycle length and high time. The bus side and the waveform generators run on separate, unrelated clocks. A configuration write does not take effect at once. It raises a per-word pending flag in a shared status word. That flag drops only once the waveform clock domain has taken the value, so software polls the flag after every write before moving on to the next field of that channel.

Each word crosses between the clocks through a toggle request and a toggle acknowledge, each passing through two synchronizer flops. The cycle-length and high-time words can be deferred until the end of the running cycle, so that a waveform never shows a mix of old and new settings. In that case the pending flag stays up until that boundary. Control changes use read-modify-write from software, since every word reads back as it was last written.

Top module: `pwm_dual_top`

## Requirements
- R1: Channel c (0 or 1) keeps its words at byte address c*16 plus a field offset: control +0x0, divider +0x4, cycle length +0x8, high time +0xC. Each word reads back the last value written to it, in all 32 bits.
- R2: The status word at 0x40 gives channel c's flags in bits 8c+3..8c. Bit 0 of a lane is control, bit 1 divider, bit 2 cycle length and bit 3 high time. All other bits read 0.
- R3: A write to a configuration word sets its flag in the cycle that follows the write. The flag clears by itself once the waveform domain has taken the value.
- R4: A second write to a word whose flag is still set keeps the flag set. The newest value is the one read back and the one finally applied.
- R5: The waveform clock is divided by (divider+1), and one output cycle lasts (divider+1)*(length+1) waveform clocks.
- R6: The output is high for high_time*(divider+1) clocks of each cycle when control bit 1 is 0. When control bit 1 is 1, the output is inverted.
- R7: With control bit 2 (deferred load) set on a running channel, new cycle-length and high-time values take effect at the cycle boundary, and their flags clear at that moment.
- R8: When control bit 0 (run) is cleared with control bit 3 low, the output completes its current cycle and then holds the inactive level (low, or high if inverted).
- R9: When control bit 0 is cleared with control bit 3 (halt now) set, the output goes to its inactive level one waveform clock after the control value is taken.
- R10: The status word cannot be written. A write to 0x40 changes no flag.
- R11: Reset clears every word, every flag and both outputs.
- R12: The two channels run independently. Reconfiguring one does not change the other's waveform.
- R13: A control value with bit 5 set applies any deferred cycle-length and high-time values at once and restarts the cycle. Bit 4 restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register-file clock |
| pwmClk | input | 1 | Waveform clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busWe | input | 1 | Write strobe, sampled on busClk |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | CH_N | One waveform output per channel |

## Verification
The waveform is measured from rising edge to rising edge with several settings: no division against division by two and three, a short cycle against a 200-clock cycle, and normal against inverted polarity. These settings separate a wrong divider from a wrong cycle counter, and a wrong compare from a missing inversion. Flags are read right after a write, partway through a deferred cycle, and after a second write to the same word. This separates immediate application from a deferred load, and a load at the boundary from a load forced by control bit 5. Stopping is tried at the start of a long high phase, so a halt that takes effect at once differs visibly from one that finishes the cycle.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int DATA_W      = 32;
  localparam int REGS_PER_CH = 4;
  localparam int CTRL_W      = 6;

  // field slots within a channel (address offset = slot*4)
  localparam int F_CTRL   = 0;
  localparam int F_DIV    = 1;
  localparam int F_LENGTH = 2;
  localparam int F_HIGH   = 3;

  // control bit positions
  localparam int C_RUN     = 0;
  localparam int C_INVERT  = 1;
  localparam int C_DEFER   = 2;
  localparam int C_HALTNOW = 3;
  localparam int C_RSTDIV  = 4;
  localparam int C_RSTCYC  = 5;

  // strobes and held values from the bus side into one channel
  typedef struct packed {
    logic [REGS_PER_CH-1:0]             reqTog;
    logic [REGS_PER_CH-1:0][DATA_W-1:0] data;
  } chan_link_t;
endpackage

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
  import pwm_dual_pkg::*;
#(
  parameter int CH_N   = 2,
  parameter int ADDR_W = 7
) (
  input  logic                               busClk,
  input  logic                               rstN,
  input  logic                               busWe,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [DATA_W-1:0]                  busWdata,
  output logic [DATA_W-1:0]                  busRdata,
  input  logic [CH_N-1:0][REGS_PER_CH-1:0]   ackTog,
  output chan_link_t [CH_N-1:0]              link,
  output logic [CH_N*REGS_PER_CH-1:0]        pendVec
);
  localparam int SLOTS  = CH_N * REGS_PER_CH;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(7'h40);

  logic [SLOTS-1:0][DATA_W-1:0] held, xfer;
  logic [SLOTS-1:0] reqTog, dirty, inFlight, ackFlat, ackS1, ackS2, ackPrev, ackEv, wrHit;
  logic regSpace;
  logic [SLOT_W-1:0] slot;

  assign ackFlat = ackTog;

  always_comb begin
    regSpace = (busAddr[ADDR_W-1:SLOT_W+2] == '0);
    slot     = busAddr[SLOT_W+1:2];
    wrHit    = '0;
    if (busWe && regSpace) wrHit[slot] = 1'b1;
    ackEv    = ackS2 ^ ackPrev;
    pendVec  = dirty | inFlight;
  end

  always_comb begin
    busRdata = '0;
    if (regSpace) begin
      busRdata = held[slot];
    end else if (busAddr == STATUS_ADDR) begin
      for (int ch = 0; ch < CH_N; ch++)
        busRdata[ch*8 +: REGS_PER_CH] = pendVec[ch*REGS_PER_CH +: REGS_PER_CH];
    end
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      held <= '0; xfer <= '0; reqTog <= '0; dirty <= '0; inFlight <= '0;
      ackS1 <= '0; ackS2 <= '0; ackPrev <= '0;
    end else begin
      ackS1   <= ackFlat;
      ackS2   <= ackS1;
      ackPrev <= ackS2;
      for (int s = 0; s < SLOTS; s++) begin
        if (inFlight[s] && ackEv[s]) begin
          inFlight[s] <= 1'b0;
        end else if (!inFlight[s] && dirty[s]) begin
          xfer[s]     <= held[s];
          reqTog[s]   <= ~reqTog[s];
          inFlight[s] <= 1'b1;
          dirty[s]    <= 1'b0;
        end
        if (wrHit[s]) begin
          held[s]  <= busWdata;
          dirty[s] <= 1'b1;
        end
      end
    end
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_link
    assign link[ch].reqTog = reqTog[ch*REGS_PER_CH +: REGS_PER_CH];
    assign link[ch].data   = xfer[ch*REGS_PER_CH +: REGS_PER_CH];
  end
endmodule

// File: rtl/pwm_dual_chan.sv
module pwm_dual_chan
  import pwm_dual_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   pwmClk,
  input  logic                   rstN,
  input  chan_link_t             link,
  output logic [REGS_PER_CH-1:0] ackTog,
  output logic                   pwmOut
);
  logic [REGS_PER_CH-1:0] reqS1, reqS2, reqPrev, ev;
  logic [CTRL_W-1:0] ctrl, newCtrl;
  logic [CNT_W-1:0] divVal, lenVal, highVal, shLen, shHigh, divCnt, cycCnt;
  logic [CNT_W-1:0] newDiv, newLen, newHigh;
  logic shPendLen, shPendHigh, running, stopPend;
  logic tick, wrap, ctrlRestart, applyNow, deferLoad;
  logic unusedHi;

  always_comb begin
    ev          = reqS2 ^ reqPrev;
    newCtrl     = link.data[F_CTRL][CTRL_W-1:0];
    newDiv      = link.data[F_DIV][CNT_W-1:0];
    newLen      = link.data[F_LENGTH][CNT_W-1:0];
    newHigh     = link.data[F_HIGH][CNT_W-1:0];
    tick        = running && (divCnt >= divVal);
    wrap        = tick && (cycCnt >= lenVal);
    ctrlRestart = ev[F_CTRL] && newCtrl[C_RSTCYC];
    applyNow    = wrap || ctrlRestart || !running;
    deferLoad   = ctrl[C_DEFER] && running;
    unusedHi    = ^{link.data[F_CTRL][DATA_W-1:CTRL_W], link.data[F_DIV][DATA_W-1:CNT_W],
                    link.data[F_LENGTH][DATA_W-1:CNT_W], link.data[F_HIGH][DATA_W-1:CNT_W]};
  end

  always_ff @(posedge pwmClk or negedge rstN) begin
    if (!rstN) begin
      reqS1 <= '0; reqS2 <= '0; reqPrev <= '0; ackTog <= '0;
      ctrl <= '0; divVal <= '0; lenVal <= '0; highVal <= '0; shLen <= '0; shHigh <= '0;
      shPendLen <= 1'b0; shPendHigh <= 1'b0; divCnt <= '0; cycCnt <= '0;
      running <= 1'b0; stopPend <= 1'b0; pwmOut <= 1'b0;
    end else begin
      reqS1   <= link.reqTog;
      reqS2   <= reqS1;
      reqPrev <= reqS2;

      // divider and cycle counter
      if (!running) begin
        divCnt <= '0; cycCnt <= '0;
      end else if (tick) begin
        divCnt <= '0;
        cycCnt <= wrap ? '0 : cycCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (stopPend && wrap) begin
        running <= 1'b0; stopPend <= 1'b0;
      end

      if (ev[F_DIV]) begin
        divVal <= newDiv; ackTog[F_DIV] <= ~ackTog[F_DIV];
      end

      if (ev[F_LENGTH]) begin
        shLen <= newLen;
        if (deferLoad) shPendLen <= 1'b1;
        else begin lenVal <= newLen; ackTog[F_LENGTH] <= ~ackTog[F_LENGTH]; end
      end else if (shPendLen && applyNow) begin
        lenVal <= shLen; shPendLen <= 1'b0; ackTog[F_LENGTH] <= ~ackTog[F_LENGTH];
      end

      if (ev[F_HIGH]) begin
        shHigh <= newHigh;
        if (deferLoad) shPendHigh <= 1'b1;
        else begin highVal <= newHigh; ackTog[F_HIGH] <= ~ackTog[F_HIGH]; end
      end else if (shPendHigh && applyNow) begin
        highVal <= shHigh; shPendHigh <= 1'b0; ackTog[F_HIGH] <= ~ackTog[F_HIGH];
      end

      if (ev[F_CTRL]) begin
        ctrl <= newCtrl;
        ackTog[F_CTRL] <= ~ackTog[F_CTRL];
        if (newCtrl[C_RSTDIV]) divCnt <= '0;
        if (ctrlRestart) begin divCnt <= '0; cycCnt <= '0; end
        if (newCtrl[C_RUN]) begin
          running <= 1'b1; stopPend <= 1'b0;
        end else if (newCtrl[C_HALTNOW]) begin
          running <= 1'b0; stopPend <= 1'b0;
        end else if (running) begin
          stopPend <= 1'b1;
        end
      end

      pwmOut <= running ? ((cycCnt < highVal) ^ ctrl[C_INVERT]) : ctrl[C_INVERT];
    end
  end
endmodule

// File: rtl/pwm_dual_top.sv
module pwm_dual_top
  import pwm_dual_pkg::*;
#(
  parameter int CH_N   = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 7
) (
  input  logic              busClk,
  input  logic              pwmClk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [CH_N-1:0]   pwmOut
);
  chan_link_t [CH_N-1:0]             link;
  logic [CH_N-1:0][REGS_PER_CH-1:0]  ackTog;
  logic [CH_N*REGS_PER_CH-1:0]       pendVec;

  pwm_dual_regs #(.CH_N(CH_N), .ADDR_W(ADDR_W)) u_regs (
    .busClk(busClk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ackTog(ackTog),
    .link(link), .pendVec(pendVec)
  );

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
    pwm_dual_chan #(.CNT_W(CNT_W)) u_chan (
      .pwmClk(pwmClk), .rstN(rstN), .link(link[ch]),
      .ackTog(ackTog[ch]), .pwmOut(pwmOut[ch])
    );
  end
endmodule

// File: rtl/pwm_dual_checker.sv
module pwm_dual_checker #(
  parameter int CH_N   = 2,
  parameter int ADDR_W = 7
) (
  input logic                   busClk,
  input logic                   rstN,
  input logic                   busWe,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [31:0]            busWdata,
  input logic [31:0]            busRdata,
  input logic [CH_N-1:0]        pwmOut,
  input logic [CH_N*4-1:0]      pendVec
);
  localparam int SLOT_W = $clog2(CH_N * 4);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(7'h40);

  logic inRegSpace;
  assign inRegSpace = (busAddr[ADDR_W-1:SLOT_W+2] == '0);

  a_r3_write_sets_pending: assert property (@(posedge busClk) disable iff (!rstN)
    (busWe && inRegSpace) |=> pendVec[$past(busAddr[SLOT_W+1:2])]);

  a_r1_readback: assert property (@(posedge busClk) disable iff (!rstN)
    ($past(busWe) && !busWe && inRegSpace && busAddr == $past(busAddr))
      |-> busRdata == $past(busWdata));

  a_r10_status_readonly: assert property (@(posedge busClk) disable iff (!rstN)
    (busWe && busAddr == STATUS_ADDR && pendVec == '0) |=> pendVec == '0);

  a_r11_reset_state: assert property (@(posedge busClk)
    !rstN |-> (pendVec == '0 && pwmOut == '0 && busRdata == '0));

  a_r6_output_known: assert property (@(posedge busClk) disable iff (!rstN)
    !$isunknown(pwmOut));
endmodule

bind pwm_dual_top pwm_dual_checker #(.CH_N(CH_N), .ADDR_W(ADDR_W)) u_chk (
  .busClk(busClk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut), .pendVec(pendVec)
);

// File: tb/pwm_dual_top_tb_top.sv
module pwm_dual_top_tb_top;
  logic        busClk = 1'b0;
  logic        pwmClk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  pwmOut;
  logic        rdStb = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 busClk = ~busClk;   // 50 MHz
  always #18 pwmClk = ~pwmClk;

  pwm_dual_top dut_i (
    .busClk(busClk), .pwmClk(pwmClk), .rstN(rstN), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  // monitor: pops expected read data and compares
  initial begin
    logic [31:0] e;
    string t;
    forever begin
      @(negedge busClk);
      if (rdStb) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (busRdata !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, busRdata, e);
        end
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge busClk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge busClk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(posedge busClk); #1;
    expQ.push_back(exp); tagQ.push_back(tag);
    busAddr = a; rdStb = 1'b1;
    @(negedge busClk); #1;
    rdStb = 1'b0;
  endtask

  task automatic rdRaw(input logic [6:0] a, output logic [31:0] v);
    @(posedge busClk); #1;
    busAddr = a;
    @(negedge busClk);
    v = busRdata;
  endtask

  task automatic waitClear(input logic [31:0] mask, input string tag, input int limit);
    logic [31:0] v;
    bit ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      rdRaw(7'h40, v);
      if ((v & mask) == 0) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      checks++; errors++;
      $display("FAIL %s: flags %h still set, expected 0", tag, mask);
    end
  endtask

  task automatic cfgWr(input logic [6:0] a, input logic [31:0] d, input logic [31:0] mask,
                       input string tag);
    wr(a, d);
    waitClear(mask, tag, 3000);
  endtask

  task automatic waitRise(input int ch);
    logic p;
    @(negedge pwmClk);
    p = pwmOut[ch];
    for (int i = 0; i < 5000; i++) begin
      @(negedge pwmClk);
      if (!p && pwmOut[ch]) return;
      p = pwmOut[ch];
    end
  endtask

  task automatic measure(input int ch, output int per, output int hi);
    logic p;
    waitRise(ch);
    per = 1; hi = 1; p = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge pwmClk);
      if (!p && pwmOut[ch]) break;
      per++;
      if (pwmOut[ch]) hi++;
      p = pwmOut[ch];
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per, hi, cnt;
    repeat (5) @(negedge busClk);
    rstN = 1'b1;

    // R11 reset state
    rdChk(7'h00, 32'h0, "R11 ctrl0 after reset");
    rdChk(7'h1C, 32'h0, "R11 high1 after reset");
    rdChk(7'h40, 32'h0, "R11 status after reset");
    check("R11 outputs after reset", int'(pwmOut), 0);

    // R10 status not writable
    wr(7'h40, 32'hFFFF_FFFF);
    rdChk(7'h40, 32'h0, "R10 status write ignored");

    // R3 flag set then cleared
    wr(7'h04, 32'h0);
    rdChk(7'h40, 32'h2, "R3 divider flag set after write");
    waitClear(32'h2, "R3 divider flag clears", 3000);
    rdChk(7'h40, 32'h0, "R3 status idle");

    cfgWr(7'h08, 9, 32'h4, "R3 length0");
    cfgWr(7'h0C, 3, 32'h8, "R3 high0");
    rdChk(7'h08, 32'd9, "R1 length0 readback");
    rdChk(7'h0C, 32'd3, "R1 high0 readback");
    cfgWr(7'h00, 32'h1, 32'h1, "R3 ctrl0");
    measure(0, per, hi);
    check("R5 ch0 cycle, divider 0", per, 10);
    check("R6 ch0 high time", hi, 3);

    // channel 1: divider 1, inverted
    wr(7'h14, 32'h1);
    rdChk(7'h40, 32'h200, "R2 ch1 divider flag in second byte lane");
    waitClear(32'h200, "R2 ch1 divider", 3000);
    cfgWr(7'h18, 4, 32'h400, "R3 length1");
    cfgWr(7'h1C, 2, 32'h800, "R3 high1");
    cfgWr(7'h10, 32'h3, 32'h100, "R3 ctrl1");
    rdChk(7'h10, 32'h3, "R1 ctrl1 readback");
    measure(1, per, hi);
    check("R5 ch1 cycle, divider 1", per, 10);
    check("R6 ch1 inverted high time", hi, 6);
    measure(0, per, hi);
    check("R12 ch0 cycle unchanged", per, 10);
    check("R12 ch0 high unchanged", hi, 3);

    // R5 divider 2
    cfgWr(7'h04, 2, 32'h2, "R5 divider0");
    measure(0, per, hi);
    check("R5 ch0 cycle, divider 2", per, 30);
    check("R6 ch0 high, divider 2", hi, 9);
    cfgWr(7'h04, 0, 32'h2, "R5 divider0 back");

    // long cycle, deferred loading
    cfgWr(7'h08, 199, 32'h4, "R7 length0");
    cfgWr(7'h0C, 50, 32'h8, "R7 high0");
    cfgWr(7'h00, 32'h5, 32'h1, "R7 ctrl0 defer");
    waitRise(0);
    wr(7'h0C, 100);
    repeat (30) @(negedge busClk);
    rdChk(7'h40, 32'h8, "R7 high flag held until boundary");
    wr(7'h0C, 120);
    rdChk(7'h40, 32'h8, "R4 flag stays set on rewrite");
    rdChk(7'h0C, 32'd120, "R4 newest value read back");
    waitClear(32'h8, "R7 high flag clears at boundary", 3000);
    measure(0, per, hi);
    check("R4 newest high time applied", hi, 120);
    check("R7 cycle length", per, 200);

    // R13 restart bit applies deferred value now
    waitRise(0);
    wr(7'h0C, 60);
    repeat (20) @(negedge busClk);
    rdChk(7'h40, 32'h8, "R13 high flag waiting");
    wr(7'h00, 32'h25);
    repeat (40) @(negedge busClk);
    rdChk(7'h40, 32'h0, "R13 restart bit clears deferred flag early");
    measure(0, per, hi);
    check("R13 high time after restart load", hi, 60);

    cfgWr(7'h00, 32'h5, 32'h1, "R8 ctrl0 rewrite");
    cfgWr(7'h0C, 150, 32'h8, "R8 high0");

    // R8 stop at end of cycle
    waitRise(0);
    wr(7'h00, 32'h4);
    waitClear(32'h1, "R8 ctrl0 disable", 3000);
    @(negedge pwmClk);
    check("R8 output continues in current cycle", int'(pwmOut[0]), 1);
    repeat (250) @(negedge pwmClk);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge pwmClk);
      if (pwmOut[0]) cnt++;
    end
    check("R8 output idle low after cycle", cnt, 0);

    // R9 halt at once
    cfgWr(7'h00, 32'h5, 32'h1, "R9 ctrl0 enable");
    waitRise(0);
    wr(7'h00, 32'hC);
    waitClear(32'h1, "R9 ctrl0 halt", 3000);
    repeat (2) @(negedge busClk);
    check("R9 output forced inactive", int'(pwmOut[0]), 0);

    measure(1, per, hi);
    check("R12 ch1 cycle unchanged", per, 10);
    check("R12 ch1 high unchanged", hi, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule